// File: doc/BRIEF.md
# Wait-State and Burst Ready Controller

This controller sits on the processor side of a system board and answers bus cycles. It watches the address strobe and the cycle attributes. Each transfer is acknowledged with an active-low ready, and the ready stays high for a chosen number of wait clocks before each acknowledge. A read that the processor marks cacheable, and that the target also confirms as cacheable, becomes a four-beat line fill. Every other selected cycle, including every write, completes with one transfer.

The block reports its phase as idle, address or data. It numbers the beats of a line fill and pulses an end-of-cycle flag together with the final acknowledge. Strobes that arrive while the target is not selected, or while a cycle is still open, are ignored.

Top module: `burst_ready_ctrl`

## Requirements
- R1: While reset is held, `brdy_n` is 1, `bus_state` is idle (2'b00), `beat_idx` is 0 and `cycle_done` is 0.
- R2: When `ads_n`=0 and `dev_sel`=1 are sampled at a rising edge in idle, `bus_state` becomes address (2'b01) for one clock and then data (2'b10).
- R3: A strobe sampled while `dev_sel`=0 leaves the block idle, with `brdy_n` high.
- R4: A read (`wr_n`=0) with both `cache_n`=0 and `ken_n`=0 at the strobe completes as exactly four acknowledged beats.
- R5: Any other selected cycle, writes included, completes as exactly one acknowledged beat.
- R6: In the data phase, each beat shows `brdy_n`=1 for exactly W clocks and then `brdy_n`=0 for one clock. W is the `wait_cnt` value sampled with the strobe, and later changes to `wait_cnt` have no effect on the open cycle.
- R7: `beat_idx` equals 0, 1, 2, 3 on the successive acknowledges of a line fill, equals 0 on a single transfer, and is 0 whenever the block is idle.
- R8: `cycle_done` is 1 only in the clock of the final acknowledge of a cycle.
- R9: The clock after the final acknowledge is idle, with `brdy_n` high, and a strobe in that clock starts a new cycle.
- R10: A strobe, together with any attribute changes, during the address or data phase does not alter the open cycle and starts no new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ads_n | input | 1 | Address strobe, active low |
| wr_n | input | 1 | 1 = write, 0 = read |
| cache_n | input | 1 | Processor marks the cycle cacheable (active low) |
| ken_n | input | 1 | Target confirms cacheability (active low) |
| dev_sel | input | 1 | This target is addressed |
| wait_cnt | input | WAIT_W (3) | Wait clocks inserted before each acknowledge |
| brdy_n | output | 1 | Transfer acknowledge, active low |
| beat_idx | output | IDX_W (2) | Number of the current beat |
| cycle_done | output | 1 | Final-acknowledge pulse |
| bus_state | output | 2 | 00 idle, 01 address, 10 data |

## Verification
The bench builds the controller with its default sizes: four beats per line fill and a 3-bit wait setting. These sizes give the full index range 0 to 3 and wait counts from zero up to the maximum of seven. With them, the cycle-by-cycle position of every acknowledge can be predicted for the no-wait case and for the longest stretch. The attribute combinations cover every way a cycle can fall back to a single transfer. Directed runs add strobes during an open cycle and check that a new cycle can start immediately after the previous one ends.

// File: rtl/burst_ready_ctrl.sv
module burst_ready_ctrl #(
  parameter int BEATS  = 4,
  parameter int WAIT_W = 3,
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ads_n,
  input  logic              wr_n,
  input  logic              cache_n,
  input  logic              ken_n,
  input  logic              dev_sel,
  input  logic [WAIT_W-1:0] wait_cnt,
  output logic              brdy_n,
  output logic [IDX_W-1:0]  beat_idx,
  output logic              cycle_done,
  output logic [1:0]        bus_state
);

  localparam logic [1:0] ST_IDLE = 2'b00;
  localparam logic [1:0] ST_ADDR = 2'b01;
  localparam logic [1:0] ST_DATA = 2'b10;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

  logic [1:0]        state;
  logic              burst;
  logic [WAIT_W-1:0] wlat;
  logic [WAIT_W-1:0] wcnt;
  logic [IDX_W-1:0]  idx;

  wire start    = (state == ST_IDLE) && !ads_n && dev_sel;
  wire fill     = !wr_n && !cache_n && !ken_n;
  wire beat_end = (state == ST_DATA) && (wcnt == '0);
  wire last     = !burst || (idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      burst <= 1'b0;
      wlat  <= '0;
      wcnt  <= '0;
      idx   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_ADDR;
          burst <= fill;
          wlat  <= wait_cnt;
          idx   <= '0;
        end
        ST_ADDR: begin
          state <= ST_DATA;
          wcnt  <= wlat;
        end
        ST_DATA: begin
          if (wcnt != '0) begin
            wcnt <= wcnt - 1'b1;
          end else if (last) begin
            state <= ST_IDLE;
            idx   <= '0;
          end else begin
            idx  <= idx + 1'b1;
            wcnt <= wlat;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign brdy_n     = !beat_end;
  assign cycle_done = beat_end && last;
  assign beat_idx   = idx;
  assign bus_state  = state;

  assert_addr_then_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == ST_ADDR) |=> (bus_state == ST_DATA));

  assert_unselected_stays_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == ST_IDLE && !dev_sel) |=> (bus_state == ST_IDLE));

  assert_index_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!brdy_n && !cycle_done) |=> (beat_idx == $past(beat_idx) + 1'b1));

  assert_idle_index_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == ST_IDLE) |-> (beat_idx == '0));

  assert_done_then_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |=> (bus_state == ST_IDLE && brdy_n));

  assert_busy_strobe_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == ST_DATA && !cycle_done) |=> (bus_state == ST_DATA));

endmodule

// File: tb/test_burst_ready_ctrl.sv
`timescale 1ns/1ps
module test_burst_ready_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ads_n = 1'b1;
  logic       wr_n = 1'b0;
  logic       cache_n = 1'b1;
  logic       ken_n = 1'b1;
  logic       dev_sel = 1'b0;
  logic [2:0] wait_cnt = 3'd0;
  logic       brdy_n;
  logic [1:0] beat_idx;
  logic       cycle_done;
  logic [1:0] bus_state;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  burst_ready_ctrl i_burst_ready_ctrl (
    .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .wr_n(wr_n), .cache_n(cache_n),
    .ken_n(ken_n), .dev_sel(dev_sel), .wait_cnt(wait_cnt), .brdy_n(brdy_n),
    .beat_idx(beat_idx), .cycle_done(cycle_done), .bus_state(bus_state)
  );

  // {wr_n, cache_n, ken_n, dev_sel, wait[2:0], expected beats[2:0]}
  localparam int NV = 9;
  localparam logic [9:0] VEC [NV] = '{
    10'b0_0_0_1_000_100,
    10'b0_1_0_1_000_001,
    10'b0_0_1_1_010_001,
    10'b1_0_0_1_001_001,
    10'b0_0_0_1_011_100,
    10'b0_0_0_1_111_100,
    10'b0_0_0_0_000_000,
    10'b1_1_1_1_111_001,
    10'b0_0_0_1_001_100
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_cycle(input logic wr, input logic ca, input logic ke, input logic sel,
                           input logic [2:0] w, input int nb, input bit disturb);
    string btag;
    btag = (nb == 4) ? "R4" : "R5";
    @(negedge clk);
    ads_n = 1'b0; wr_n = wr; cache_n = ca; ken_n = ke; dev_sel = sel; wait_cnt = w;
    @(negedge clk);
    if (nb == 0) begin
      ads_n = 1'b1;
      check(bus_state == 2'b00, "R3", bus_state, 0);
      check(brdy_n == 1'b1, "R3", brdy_n, 1);
      @(negedge clk);
      check(bus_state == 2'b00, "R3", bus_state, 0);
      return;
    end
    check(bus_state == 2'b01, "R2", bus_state, 1);
    if (disturb) begin
      ads_n = 1'b0; wr_n = ~wr; cache_n = 1'b1; wait_cnt = 3'd0;
    end else begin
      ads_n = 1'b1;
    end
    for (int k = 0; k < nb; k++) begin
      for (int j = 0; j < int'(w); j++) begin
        @(negedge clk);
        check(brdy_n == 1'b1, "R6", brdy_n, 1);
        check(bus_state == 2'b10, disturb ? "R10" : "R2", bus_state, 2);
      end
      @(negedge clk);
      check(brdy_n == 1'b0, "R6", brdy_n, 0);
      check(beat_idx == 2'(k), "R7", beat_idx, k);
      if (k == nb - 1) begin
        check(cycle_done == 1'b1, btag, cycle_done, 1);
        ads_n = 1'b1;
      end else begin
        check(cycle_done == 1'b0, "R8", cycle_done, 0);
      end
    end
    @(negedge clk);
    check(bus_state == 2'b00, "R9", bus_state, 0);
    check(brdy_n == 1'b1, "R9", brdy_n, 1);
    check(cycle_done == 1'b0, "R8", cycle_done, 0);
    check(beat_idx == 2'd0, "R7", beat_idx, 0);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(brdy_n == 1'b1, "R1", brdy_n, 1);
    check(bus_state == 2'b00, "R1", bus_state, 0);
    check(beat_idx == 2'd0, "R1", beat_idx, 0);
    check(cycle_done == 1'b0, "R1", cycle_done, 0);
    ads_n = 1'b0; dev_sel = 1'b1;
    @(negedge clk);
    check(bus_state == 2'b00, "R1", bus_state, 0);
    ads_n = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      run_cycle(VEC[v][9], VEC[v][8], VEC[v][7], VEC[v][6], VEC[v][5:3], int'(VEC[v][2:0]), 1'b0);
    end

    // R10 / R6: strobe and attribute changes while a fill is open
    run_cycle(1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 4, 1'b1);
    @(negedge clk);
    check(bus_state == 2'b00, "R10", bus_state, 0);
    check(brdy_n == 1'b1, "R10", brdy_n, 1);

    // R9: back-to-back cycles, single followed at once by a fill
    run_cycle(1'b1, 1'b1, 1'b1, 1'b1, 3'd0, 1, 1'b0);
    run_cycle(1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 4, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule